// File: doc/BRIEF.md
# Integer to Floating-Point Converter

This block turns a 64-bit integer operand into the bit pattern of an IEEE-754 binary16, binary32 or binary64 number. The operand can be read as unsigned or as two's complement. A format select picks the target precision. The converted value always comes out rounded to nearest, with ties going to the even neighbour.

The datapath works in five steps:
- When the operand is signed and negative, it is negated to get a magnitude.
- The leading zeros of the magnitude are counted. Two 32-bit counters are combined to form the 64-bit count.
- The magnitude is shifted left so that its leading one sits in the top bit.
- For each format, a packer takes the fraction, builds the biased exponent and folds in the round and sticky bits.
- The packer adds the round bit to the exponent and fraction taken together, so any carry out of the fraction moves into the exponent.

Half precision also has a shortcut: any magnitude that does not fit in 32 bits goes straight to infinity.

A request is one cycle with `in_valid` high plus the operand and its flags. The result is registered and appears one clock later together with `out_valid`. Narrow results are right-aligned in the 64-bit output, and the unused upper bits are zero.

Top module: `int2fp_conv`

## Requirements
- R1: `out_valid` equals `in_valid` of the previous cycle. `out_result` changes only one cycle after a cycle with `in_valid` high, and it holds its value in every other cycle.
- R2: While `rst` is high at a clock edge, `out_valid` and `out_result` are cleared to zero.
- R3: `in_fmt` selects the target format:
  - 2'b00 gives half precision in bits 15:0.
  - 2'b01 gives single precision in bits 31:0.
  - 2'b10 and the reserved code 2'b11 both give double precision in bits 63:0.
  - All result bits above the selected format are zero.
- R4: Magnitudes that are exactly representable convert without error. Examples: 1 gives 0x3FF0000000000000, 0x3F800000 or 0x3C00, and 1000 in single precision gives 0x447A0000.
- R5: A zero operand gives an all-zero result in every format and for both signedness settings.
- R6: When the dropped part is below half an ulp, it is truncated. When it is above half an ulp, the result rounds up. Examples: 2^54+1 gives 0x4350000000000000 and 2^54+3 gives 0x4350000000000001 in double.
- R7: An exact tie rounds to the even fraction. Examples: 2^53+1 gives 0x4340000000000000, 2^53+3 gives 0x4340000000000002, 2^24+3 gives 0x4B800002 and 2049 gives 0x6800 in half.
- R8: A round-up that overflows the fraction carries into the exponent. Examples: 2^32-1 in single gives 0x4F800000, and 2^64-1 in double gives 0x43F0000000000000.
- R9: The unsigned maximum 2^64-1 gives 0x5F800000 in single precision.
- R10: With `in_signed` high and bit 63 set, the magnitude of the two's complement is converted and the sign bit of the result is set. Examples: -1 gives 0xBFF0000000000000, -2^63 gives 0xC3E0000000000000, and -3 in single gives 0xC0400000.
- R11: With `in_signed` low, bit 63 is part of the magnitude. 0x8000000000000000 gives 0x43E0000000000000.
- R12: In half precision, a nonzero upper 32-bit word of the magnitude gives infinity, 0x7C00, with the sign applied for negative signed operands (0xFC00). A lower-word magnitude that rounds to 65520 or more also gives 0x7C00, while 65519 gives 0x7BFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operand and flags are presented this cycle |
| in_operand | input | 64 | Integer operand |
| in_signed | input | 1 | 1: operand is two's complement; 0: unsigned |
| in_fmt | input | 2 | Target format: 00 half, 01 single, 10/11 double |
| out_valid | output | 1 | Result register holds a new conversion |
| out_result | output | 64 | Floating-point bit pattern, right-aligned |

## Verification
The operands are chosen so that each one tells a specific defect apart:
- Powers of two and small integers separate exponent-bias errors from fraction errors.
- Values just above 2^53, 2^54 and 2^24 place the dropped bits at below half, above half and exactly half an ulp. A tie with an odd kept fraction next to a tie with an even kept fraction exposes a missing or inverted ties-to-even step.
- All-ones operands force the fraction carry into the exponent.
- Signed and unsigned readings of the same bit patterns, including -2^63, separate the negation path from the unsigned one.
- Half-precision cases straddle the 65504/65520 boundary and the upper-word shortcut.

// File: rtl/i2f_pkg.sv
package i2f_pkg;
  typedef enum logic [1:0] {
    FMT_HALF   = 2'b00,
    FMT_SINGLE = 2'b01,
    FMT_DOUBLE = 2'b10,
    FMT_RSVD   = 2'b11
  } fmt_e;

  localparam int HALF_EXP_W = 5;
  localparam int HALF_FRAC_W = 10;
  localparam int SGL_EXP_W = 8;
  localparam int SGL_FRAC_W = 23;
  localparam int DBL_EXP_W = 11;
  localparam int DBL_FRAC_W = 52;
endpackage

// File: rtl/i2f_lzc.sv
module i2f_lzc #(
  parameter int W = 32,
  localparam int CW = $clog2(W) + 1
) (
  input  logic [W-1:0]  vec,
  output logic [CW-1:0] count
);
  always_comb begin
    logic found;
    found = 1'b0;
    count = CW'(W);
    for (int i = W - 1; i >= 0; i--) begin
      if (!found && vec[i]) begin
        count = CW'(W - 1 - i);
        found = 1'b1;
      end
    end
  end
endmodule

// File: rtl/i2f_lzc_split.sv
module i2f_lzc_split #(
  parameter int W = 64,
  localparam int HW = W / 2,
  localparam int HCW = $clog2(HW) + 1,
  localparam int CW = $clog2(W) + 1
) (
  input  logic [W-1:0]  vec,
  output logic [CW-1:0] count
);
  logic [HCW-1:0] part_cnt [2];

  // index 0 counts the lower word, index 1 the upper word
  for (genvar g = 0; g < 2; g++) begin : g_half
    i2f_lzc #(.W(HW)) cnt_i (
      .vec   (vec[g*HW +: HW]),
      .count (part_cnt[g])
    );
  end

  // the lower-word count only matters once the upper word is all zero
  always_comb begin
    if (part_cnt[1] == HCW'(HW))
      count = CW'(HW) + CW'(part_cnt[0]);
    else
      count = CW'(part_cnt[1]);
  end
endmodule

// File: rtl/i2f_pack.sv
module i2f_pack #(
  parameter int OP_W = 64,
  parameter int EXP_W = 11,
  parameter int FRAC_W = 52,
  localparam int LZW = $clog2(OP_W) + 1,
  localparam int EW = EXP_W + 2,
  localparam int SW = EW + FRAC_W,
  localparam int BIAS = (1 << (EXP_W - 1)) - 1,
  localparam int RPOS = OP_W - 2 - FRAC_W,
  localparam int RES_W = 1 + EXP_W + FRAC_W
) (
  input  logic [OP_W-1:0]  norm,
  input  logic [LZW-1:0]   lz,
  input  logic             zero,
  input  logic             neg,
  output logic [RES_W-1:0] result
);
  localparam logic [SW-1:0] INF_MAG = {2'b00, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
  localparam logic [OP_W-1:0] STICKY_MASK = (OP_W'(1) << RPOS) - OP_W'(1);

  logic [EW-1:0]     exp_w;
  logic [FRAC_W-1:0] frac;
  logic              rnd, sticky;
  logic [SW-1:0]     sum, sat;

  always_comb begin
    exp_w  = EW'(BIAS + OP_W - 1) - EW'(lz);
    frac   = norm[OP_W-2 -: FRAC_W];
    rnd    = norm[RPOS];
    sticky = |(norm & STICKY_MASK);
    // adding the round bit to {exponent, fraction} lets a carry bump the exponent
    sum = {exp_w, frac} + SW'(rnd);
    if (rnd && !sticky)
      sum[0] = 1'b0;
    sat = (sum >= INF_MAG) ? INF_MAG : sum;
    if (zero)
      result = '0;
    else
      result = {neg, sat[EXP_W+FRAC_W-1:0]};
  end
endmodule

// File: rtl/int2fp_conv.sv
module int2fp_conv
  import i2f_pkg::*;
#(
  parameter int OP_W = 64,
  localparam int LZW = $clog2(OP_W) + 1,
  localparam int HW = OP_W / 2,
  localparam int H_W = 1 + HALF_EXP_W + HALF_FRAC_W,
  localparam int S_W = 1 + SGL_EXP_W + SGL_FRAC_W,
  localparam int D_W = 1 + DBL_EXP_W + DBL_FRAC_W
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            in_valid,
  input  logic [OP_W-1:0] in_operand,
  input  logic            in_signed,
  input  logic [1:0]      in_fmt,
  output logic            out_valid,
  output logic [D_W-1:0]  out_result
);
  logic            neg, zero, hi_nz;
  logic [OP_W-1:0] mag, norm;
  logic [LZW-1:0]  lz;
  logic [H_W-1:0]  res_h, res_h_fin;
  logic [S_W-1:0]  res_s;
  logic [D_W-1:0]  res_d, res_sel;

  always_comb begin
    neg = in_signed & in_operand[OP_W-1];
    mag = neg ? (~in_operand + OP_W'(1)) : in_operand;
  end

  i2f_lzc_split #(.W(OP_W)) lzc_i (.vec(mag), .count(lz));

  always_comb begin
    zero  = (mag == '0);
    norm  = mag << lz;
    hi_nz = |mag[OP_W-1:HW];
  end

  i2f_pack #(.OP_W(OP_W), .EXP_W(HALF_EXP_W), .FRAC_W(HALF_FRAC_W)) pack_h_i (
    .norm(norm), .lz(lz), .zero(zero), .neg(neg), .result(res_h));
  i2f_pack #(.OP_W(OP_W), .EXP_W(SGL_EXP_W), .FRAC_W(SGL_FRAC_W)) pack_s_i (
    .norm(norm), .lz(lz), .zero(zero), .neg(neg), .result(res_s));
  i2f_pack #(.OP_W(OP_W), .EXP_W(DBL_EXP_W), .FRAC_W(DBL_FRAC_W)) pack_d_i (
    .norm(norm), .lz(lz), .zero(zero), .neg(neg), .result(res_d));

  // half shortcut: anything wider than the lower word cannot fit
  always_comb begin
    if (hi_nz)
      res_h_fin = {neg, {HALF_EXP_W{1'b1}}, {HALF_FRAC_W{1'b0}}};
    else
      res_h_fin = res_h;
    case (fmt_e'(in_fmt))
      FMT_HALF:   res_sel = D_W'(res_h_fin);
      FMT_SINGLE: res_sel = D_W'(res_s);
      default:    res_sel = res_d;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid  <= 1'b0;
      out_result <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid)
        out_result <= res_sel;
    end
  end

  assert_valid_lat_R1: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  assert_idle_lat_R1: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!out_valid && $stable(out_result)));
  assert_narrow_upper_R3: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_fmt == 2'b00) |=> (out_result[D_W-1:H_W] == '0));
  assert_zero_in_R5: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_operand == '0) |=> (out_result == '0));
  assert_norm_lead_R4: assert property (@(posedge clk) disable iff (rst)
    (mag != '0) |-> norm[OP_W-1]);
  assert_neg_sign_R10: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_signed && in_operand[OP_W-1] && in_fmt[1]) |=> out_result[D_W-1]);
  assert_half_ovf_R12: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !in_signed && in_fmt == 2'b00 && |in_operand[OP_W-1:HW])
      |=> (out_result[H_W-1:0] == 16'h7C00));
endmodule

// File: tb/int2fp_conv_tb_top.sv
`timescale 1ns/1ps
module int2fp_conv_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [63:0] in_operand = '0;
  logic        in_signed = 1'b0;
  logic [1:0]  in_fmt = 2'b10;
  logic        out_valid;
  logic [63:0] out_result;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #2 clk = ~clk;

  int2fp_conv dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_operand(in_operand),
    .in_signed(in_signed), .in_fmt(in_fmt), .out_valid(out_valid),
    .out_result(out_result));

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%h expected=0x%h", req, act, exp);
    end
  endtask

  task automatic conv(input string req, input logic [63:0] op, input logic sgn,
                      input logic [1:0] f, input logic [63:0] exp);
    @(negedge clk);
    in_valid = 1'b1; in_operand = op; in_signed = sgn; in_fmt = f;
    @(negedge clk);
    in_valid = 1'b0;
    chk({req, " valid"}, {63'b0, out_valid}, 64'd1);
    chk(req, out_result, exp);
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk("R2 valid", {63'b0, out_valid}, 64'd0);
    chk("R2 result", out_result, 64'd0);
  endtask

  task automatic t_latency_hold;
    conv("R1", 64'd1, 1'b0, 2'b10, 64'h3FF0000000000000);
    in_operand = 64'd12345;
    @(negedge clk);
    chk("R1 idle valid", {63'b0, out_valid}, 64'd0);
    chk("R1 hold", out_result, 64'h3FF0000000000000);
  endtask

  task automatic t_formats;
    conv("R3 half", 64'd1, 1'b0, 2'b00, 64'h3C00);
    conv("R3 single", 64'd1, 1'b0, 2'b01, 64'h3F800000);
    conv("R3 reserved", 64'd1, 1'b0, 2'b11, 64'h3FF0000000000000);
    conv("R3 single neg upper", 64'hFFFFFFFFFFFFFFFD, 1'b1, 2'b01, 64'hC0400000);
  endtask

  task automatic t_exact;
    conv("R4 single 1000", 64'd1000, 1'b0, 2'b01, 64'h447A0000);
    conv("R4 double 2^53", 64'h0020000000000000, 1'b0, 2'b10, 64'h4340000000000000);
    conv("R4 half 65504", 64'd65504, 1'b0, 2'b00, 64'h7BFF);
  endtask

  task automatic t_zero;
    conv("R5 double", 64'd0, 1'b0, 2'b10, 64'd0);
    conv("R5 single signed", 64'd0, 1'b1, 2'b01, 64'd0);
    conv("R5 half", 64'd0, 1'b1, 2'b00, 64'd0);
  endtask

  task automatic t_round;
    conv("R6 below half", 64'h0040000000000001, 1'b0, 2'b10, 64'h4350000000000000);
    conv("R6 above half", 64'h0040000000000003, 1'b0, 2'b10, 64'h4350000000000001);
    conv("R7 tie even", 64'h0020000000000001, 1'b0, 2'b10, 64'h4340000000000000);
    conv("R7 tie odd", 64'h0020000000000003, 1'b0, 2'b10, 64'h4340000000000002);
    conv("R7 single tie odd", 64'h0000000001000003, 1'b0, 2'b01, 64'h4B800002);
    conv("R7 single tie even", 64'h0000000001000001, 1'b0, 2'b01, 64'h4B800000);
    conv("R7 half tie", 64'd2049, 1'b0, 2'b00, 64'h6800);
    conv("R7 half tie odd", 64'd2051, 1'b0, 2'b00, 64'h6802);
  endtask

  task automatic t_carry;
    conv("R8 single", 64'h00000000FFFFFFFF, 1'b0, 2'b01, 64'h4F800000);
    conv("R8 double", 64'hFFFFFFFFFFFFFFFF, 1'b0, 2'b10, 64'h43F0000000000000);
    conv("R9 single max", 64'hFFFFFFFFFFFFFFFF, 1'b0, 2'b01, 64'h5F800000);
  endtask

  task automatic t_signed;
    conv("R10 minus one", 64'hFFFFFFFFFFFFFFFF, 1'b1, 2'b10, 64'hBFF0000000000000);
    conv("R10 most negative", 64'h8000000000000000, 1'b1, 2'b10, 64'hC3E0000000000000);
    conv("R10 half minus one", 64'hFFFFFFFFFFFFFFFF, 1'b1, 2'b00, 64'hBC00);
    conv("R11 unsigned top bit", 64'h8000000000000000, 1'b0, 2'b10, 64'h43E0000000000000);
  endtask

  task automatic t_half_ovf;
    conv("R12 65519", 64'd65519, 1'b0, 2'b00, 64'h7BFF);
    conv("R12 65520", 64'd65520, 1'b0, 2'b00, 64'h7C00);
    conv("R12 low word max", 64'h00000000FFFFFFFF, 1'b0, 2'b00, 64'h7C00);
    conv("R12 upper word", 64'h0000000100000000, 1'b0, 2'b00, 64'h7C00);
    conv("R12 signed upper", 64'hFFFFFFFF00000000, 1'b1, 2'b00, 64'hFC00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst = 1'b0;
    t_latency_hold();
    t_formats();
    t_exact();
    t_zero();
    t_round();
    t_carry();
    t_signed();
    t_half_ovf();
    conv("R2 pre", 64'd1, 1'b0, 2'b01, 64'h3F800000);
    rst = 1'b1;
    t_reset();
    rst = 1'b0;
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule